// File: doc/BRIEF.md
# NRZI Receive Deserializer, Framer and Character Decoder

This block sits behind a clock and data recovery stage. It takes one recovered line bit per `bit_valid_i` strobe and turns NRZI line levels into NRZ bits. It shifts those bits into a 10-bit or 12-bit window. A framer watches every bit position for a sync word and locks the character boundary to the place where the sync word ends. Once locked, each full window is passed through a pair of symbol decoders. In narrow mode the pair holds two 5-bit codes and restores an 8-bit character. In wide mode it holds two 6-bit codes and restores a 10-bit character. The decoders can be bypassed so that the raw aligned window is passed out.

The recovered clock is modelled as a strobe on the core clock. Line samples with the strobe low are never consumed. `wide_i` and `bypass_i` are quasi-static and are only changed while `rst_ni` is asserted. Each character appears for one cycle on `char_o` together with `char_valid_o` and a per-code violation flag. A downstream register or FIFO captures it from there.

Top module: `nrzi_rx_align`

## Requirements
- R1: An accepted line sample is decoded to NRZ 1 when it differs from the previously accepted line level, and to 0 otherwise. The previous level is 0 after reset.
- R2: While `bit_valid_i` is low, `line_i` has no effect on any later output.
- R3: The framer checks for the sync word after every accepted bit, at any bit offset, with the first-received bit leftmost. The narrow-mode sync word is `1100010001` and the wide-mode sync word is `000000011111`. A sync word is consumed and is not output as a character. `sync_o` pulses and `locked_o` is 1 in the cycle after its last bit.
- R4: Before the first sync word, no character is output.
- R5: Once locked, a character is output after every 10 (narrow) or 12 (wide) accepted bits that follow the last boundary. `char_valid_o` is a one-cycle pulse in the cycle after the accepted bit that completes the word.
- R6: A sync word that ends on the current boundary leaves the phase unchanged. A sync word that ends at another offset moves the boundary there. A word that completes at the old phase before the new sync word ends is still output.
- R7: Narrow decode uses the 4B/5B data code set: 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101. The first-received code gives `char_o[7:4]`, the second gives `char_o[3:0]`, and `char_o[11:8]` is 0.
- R8: Wide decode treats a 6-bit code as valid when its first-received bit is 1, and its low five bits are the data. The first code gives `char_o[9:5]`, the second gives `char_o[4:0]`, and `char_o[11:10]` is 0.
- R9: `viol_o[1]` flags an invalid first code and `viol_o[0]` flags an invalid second code. The data field of an invalid code reads as 0.
- R10: With `bypass_i` high, `char_o` is the raw aligned window with the first-received bit at its MSB, zero-extended in narrow mode, and `viol_o` is 0.
- R11: After reset, `locked_o`, `sync_o` and `char_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bit_valid_i | input | 1 | Recovered-bit strobe |
| line_i | input | 1 | Recovered NRZI line level |
| wide_i | input | 1 | 0: 5-bit codes, 10-bit window; 1: 6-bit codes, 12-bit window |
| bypass_i | input | 1 | Pass raw aligned window instead of decoded character |
| locked_o | output | 1 | A sync word has been seen since reset |
| sync_o | output | 1 | One-cycle pulse after a sync word ends |
| char_valid_o | output | 1 | One-cycle pulse marking a character on `char_o` |
| char_o | output | 12 | Decoded character or raw window |
| viol_o | output | 2 | Code violation flags, [1] first code, [0] second |

## Verification
Every result of this block is due exactly one clock after the edge that accepts the bit which completes it. This holds for characters, violation flags and sync pulses alike, and nothing arrives later. The bench stamps each observed `char_valid_o` and `sync_o` pulse with the index of the last accepted bit, sampled 1 ns after that edge. During idle gaps it stamps with -1 and toggles the line level. The expected stamps are the bit indices where a word or sync word ends, computed from the transmitted stream, so any early, late, extra or missing pulse shows up as a mismatch. This covers the realignment sweeps, where the boundary moves by every possible offset.

// File: rtl/nrzi_rx_pkg.sv
package nrzi_rx_pkg;
  localparam int unsigned NCW    = 5;
  localparam int unsigned WCW    = 6;
  localparam int unsigned NWORD  = 2 * NCW;
  localparam int unsigned WWORD  = 2 * WCW;
  localparam int unsigned CHAR_W = WWORD;
  localparam int unsigned CNT_W  = $clog2(WWORD);

  localparam logic [NWORD-1:0] SYNC_N = 10'b1100010001;
  localparam logic [WWORD-1:0] SYNC_W = 12'b000000011111;

  typedef struct packed {
    logic             ok;
    logic [WCW-2:0]   dat;
  } sym_t;

  function automatic sym_t dec_5b(input logic [NCW-1:0] c);
    sym_t s;
    s.ok  = 1'b1;
    s.dat = '0;
    case (c)
      5'b11110: s.dat = 5'h0;
      5'b01001: s.dat = 5'h1;
      5'b10100: s.dat = 5'h2;
      5'b10101: s.dat = 5'h3;
      5'b01010: s.dat = 5'h4;
      5'b01011: s.dat = 5'h5;
      5'b01110: s.dat = 5'h6;
      5'b01111: s.dat = 5'h7;
      5'b10010: s.dat = 5'h8;
      5'b10011: s.dat = 5'h9;
      5'b10110: s.dat = 5'hA;
      5'b10111: s.dat = 5'hB;
      5'b11010: s.dat = 5'hC;
      5'b11011: s.dat = 5'hD;
      5'b11100: s.dat = 5'hE;
      5'b11101: s.dat = 5'hF;
      default:  s.ok  = 1'b0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/nrzi_rx_line.sv
module nrzi_rx_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_valid_i,
  input  logic line_i,
  output logic nrz_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          prev_q <= 1'b0;
    else if (bit_valid_i) prev_q <= line_i;
  end

  assign nrz_o = line_i ^ prev_q;

  // R2
  lvl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_i |=> $stable(prev_q));
endmodule

// File: rtl/nrzi_rx_framer.sv
module nrzi_rx_framer
  import nrzi_rx_pkg::*;
#(
  parameter int unsigned WIN_W = WWORD
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_valid_i,
  input  logic             nrz_i,
  input  logic             wide_i,
  output logic [WIN_W-1:0] word_o,
  output logic             word_vld_o,
  output logic             sync_o,
  output logic             locked_o
);
  localparam logic [CNT_W-1:0] LAST_N = CNT_W'(NWORD - 1);
  localparam logic [CNT_W-1:0] LAST_W = CNT_W'(WWORD - 1);

  logic [WIN_W-1:0] sr_q, win_nx, word_q;
  logic [CNT_W-1:0] cnt_q;
  logic             locked_q, sync_q, vld_q;
  logic             hit, last;

  assign win_nx = {sr_q[WIN_W-2:0], nrz_i};
  assign hit    = wide_i ? (win_nx[WWORD-1:0] == SYNC_W) : (win_nx[NWORD-1:0] == SYNC_N);
  assign last   = cnt_q == (wide_i ? LAST_W : LAST_N);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q     <= '0;
      word_q   <= '0;
      cnt_q    <= '0;
      locked_q <= 1'b0;
      sync_q   <= 1'b0;
      vld_q    <= 1'b0;
    end else begin
      sync_q <= 1'b0;
      vld_q  <= 1'b0;
      if (bit_valid_i) begin
        sr_q <= win_nx;
        if (hit) begin
          // sync wins over a boundary falling on the same bit
          cnt_q    <= '0;
          locked_q <= 1'b1;
          sync_q   <= 1'b1;
        end else if (last) begin
          cnt_q  <= '0;
          vld_q  <= locked_q;
          word_q <= win_nx;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign word_o     = word_q;
  assign word_vld_o = vld_q;
  assign sync_o     = sync_q;
  assign locked_o   = locked_q;

  // R5
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(WWORD));
  // R4
  no_word_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> locked_q);
  // R3
  sync_word_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sync_q && vld_q));
  // R2
  word_needs_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> $past(bit_valid_i));
endmodule

// File: rtl/nrzi_rx_halfdec.sv
module nrzi_rx_halfdec
  import nrzi_rx_pkg::*;
(
  input  logic [WCW-1:0] code_i,
  input  logic           wide_i,
  output sym_t           sym_o
);
  sym_t narrow_s;

  assign narrow_s = dec_5b(code_i[NCW-1:0]);

  always_comb begin
    if (wide_i) begin
      sym_o.ok  = code_i[WCW-1];
      sym_o.dat = code_i[WCW-1] ? code_i[WCW-2:0] : '0;
    end else begin
      sym_o = narrow_s;
    end
  end
endmodule

// File: rtl/nrzi_rx_align.sv
module nrzi_rx_align
  import nrzi_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_valid_i,
  input  logic              line_i,
  input  logic              wide_i,
  input  logic              bypass_i,
  output logic              locked_o,
  output logic              sync_o,
  output logic              char_valid_o,
  output logic [CHAR_W-1:0] char_o,
  output logic [1:0]        viol_o
);
  logic             nrz;
  logic [WWORD-1:0] word;
  logic             word_vld;
  sym_t             sym [2];

  nrzi_rx_line u_line (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_valid_i (bit_valid_i),
    .line_i      (line_i),
    .nrz_o       (nrz)
  );

  nrzi_rx_framer #(.WIN_W(WWORD)) u_framer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_valid_i (bit_valid_i),
    .nrz_i       (nrz),
    .wide_i      (wide_i),
    .word_o      (word),
    .word_vld_o  (word_vld),
    .sync_o      (sync_o),
    .locked_o    (locked_o)
  );

  // g=1 is the first-received code
  for (genvar g = 0; g < 2; g++) begin : g_half
    logic [WCW-1:0] code;
    assign code = wide_i ? word[g*WCW +: WCW] : {1'b0, word[g*NCW +: NCW]};
    nrzi_rx_halfdec u_dec (
      .code_i (code),
      .wide_i (wide_i),
      .sym_o  (sym[g])
    );
  end

  always_comb begin
    if (bypass_i) begin
      char_o = wide_i ? word : {2'b00, word[NWORD-1:0]};
      viol_o = 2'b00;
    end else begin
      char_o = wide_i ? {2'b00, sym[1].dat, sym[0].dat}
                      : {4'b0000, sym[1].dat[3:0], sym[0].dat[3:0]};
      viol_o = {~sym[1].ok, ~sym[0].ok};
    end
  end

  assign char_valid_o = word_vld;

  // R5
  char_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_valid_o |=> !char_valid_o);
  // R3
  lock_after_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> locked_o);
  // R3
  sync_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !sync_o);
endmodule

// File: tb/nrzi_rx_align_bench.sv
module nrzi_rx_align_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bv = 1'b0, line = 1'b0, wide = 1'b0, byp = 1'b0;
  logic locked_o, sync_o, char_valid_o;
  logic [11:0] char_o;
  logic [1:0]  viol_o;

  int tests = 0, fails = 0;
  int nb = 0, bnd = 0, nw = 0;
  logic lvl = 1'b0;
  logic lk = 1'b0;
  logic hist [0:20000];
  int gs[$], es[$], ss[$], xs[$];
  logic [11:0] gd[$], ed[$];
  logic [1:0]  gv[$], ev[$];

  always #5 clk = ~clk;

  nrzi_rx_align u_nrzi_rx_align (
    .clk_i(clk), .rst_ni(rst_n), .bit_valid_i(bv), .line_i(line),
    .wide_i(wide), .bypass_i(byp), .locked_o(locked_o), .sync_o(sync_o),
    .char_valid_o(char_valid_o), .char_o(char_o), .viol_o(viol_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] enc4(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110; 4'h1: return 5'b01001;
      4'h2: return 5'b10100; 4'h3: return 5'b10101;
      4'h4: return 5'b01010; 4'h5: return 5'b01011;
      4'h6: return 5'b01110; 4'h7: return 5'b01111;
      4'h8: return 5'b10010; 4'h9: return 5'b10011;
      4'hA: return 5'b10110; 4'hB: return 5'b10111;
      4'hC: return 5'b11010; 4'hD: return 5'b11011;
      4'hE: return 5'b11100; default: return 5'b11101;
    endcase
  endfunction

  task automatic grab(input int stamp);
    if (char_valid_o) begin
      gs.push_back(stamp); gd.push_back(char_o); gv.push_back(viol_o);
    end
    if (sync_o) ss.push_back(stamp);
  endtask

  task automatic put_bit(input logic b);
    @(negedge clk);
    lvl = lvl ^ b; line = lvl; bv = 1'b1;
    nb++; hist[nb] = b;
    @(posedge clk); #1;
    bv = 1'b0; line = ~line;  // junk while strobe low (R2)
    grab(nb);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); line = ~line;
      @(posedge clk); #1;
      grab(-1);
    end
  endtask

  task automatic put_code(input logic [11:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) put_bit(v[i]);
    nw++;
    idle(nw % 3);
  endtask

  task automatic word(input logic [11:0] v, input int w, input logic [11:0] xc, input logic [1:0] xv);
    put_code(v, w);
    if (lk) begin es.push_back(nb); ed.push_back(xc); ev.push_back(xv); bnd = nb; end
  endtask

  task automatic put_sync(input logic w);
    if (w) put_code(12'b000000011111, 12);
    else   put_code(12'b001100010001, 10);
    xs.push_back(nb); lk = 1'b1; bnd = nb;
  endtask

  function automatic logic [11:0] raw_at(input int e, input int n);
    logic [11:0] r = '0;
    for (int i = e - n + 1; i <= e; i++) r = {r[10:0], hist[i]};
    return r;
  endfunction

  task automatic compare(input string tag);
    chk(gs.size() == es.size(), {tag, " char count"}, gs.size(), es.size());
    for (int i = 0; i < gs.size() && i < es.size(); i++) begin
      chk(gs[i] == es[i], {tag, " R5 char stamp"}, gs[i], es[i]);
      chk(gd[i] == ed[i], {tag, " char value"}, gd[i], ed[i]);
      chk(gv[i] == ev[i], {tag, " R9 viol"}, gv[i], ev[i]);
    end
    chk(ss.size() == xs.size(), {tag, " R3 sync count"}, ss.size(), xs.size());
    for (int i = 0; i < ss.size() && i < xs.size(); i++)
      chk(ss[i] == xs[i], {tag, " R3 sync stamp"}, ss[i], xs[i]);
    gs.delete(); gd.delete(); gv.delete(); es.delete(); ed.delete(); ev.delete();
    ss.delete(); xs.delete();
  endtask

  task automatic do_reset(input logic w, input logic b);
    rst_n = 1'b0; bv = 1'b0; line = 1'b0; lvl = 1'b0; nb = 0; lk = 1'b0; nw = 0;
    wide = w; byp = b;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    // R11
    chk(locked_o == 1'b0, "R11 locked", locked_o, 0);
    chk(sync_o == 1'b0, "R11 sync", sync_o, 0);
    chk(char_valid_o == 1'b0, "R11 char_valid", char_valid_o, 0);
  endtask

  task automatic realign(input logic w);
    int n;
    logic [9:0] c;
    n = w ? 12 : 10;
    do_reset(w, 1'b1);
    put_sync(w);  // first bits after reset: R1 initial level
    for (int k = 0; k < n; k++) begin
      for (int j = 0; j < 2; j++) begin
        logic [11:0] v;
        c = 10'(k * 37 + j * 101 + 5);
        v = w ? {1'b1, c[9:5], 1'b1, c[4:0]} : {2'b00, enc4(c[7:4]), enc4(c[3:0])};
        word(v, n, v, 2'b00);  // R10
      end
      begin
        int old_b;
        old_b = bnd;
        for (int i = 0; i < k; i++) put_bit(1'b1);
        put_sync(w);
        // R6: word at old phase still emitted when boundary moves
        if (k > 0) begin
          es.push_back(old_b + n); ed.push_back(raw_at(old_b + n, n)); ev.push_back(2'b00);
        end
      end
    end
    c = 10'h2A5;
    word(w ? {1'b1, c[9:5], 1'b1, c[4:0]} : {2'b00, enc4(c[7:4]), enc4(c[3:0])}, n,
         w ? {1'b1, c[9:5], 1'b1, c[4:0]} : {2'b00, enc4(c[7:4]), enc4(c[3:0])}, 2'b00);
    compare(w ? "R6 R10 wide realign" : "R6 R10 narrow realign");
  endtask

  initial begin
    // narrow decode: R1 R2 R4 R7 R9
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < 4; i++) word({2'b00, enc4(4'(i)), enc4(4'(i + 3))}, 10, 12'h0, 2'b00);
    chk(locked_o == 1'b0, "R4 unlocked", locked_o, 0);
    put_sync(1'b0);
    chk(locked_o == 1'b1, "R3 locked", locked_o, 1);
    for (int c = 0; c < 256; c++)
      word({2'b00, enc4(4'(c >> 4)), enc4(4'(c))}, 10, 12'(c), 2'b00);
    for (int x = 0; x < 16; x++) begin
      word({2'b00, 5'b11111, enc4(4'(x))}, 10, 12'(x), 2'b10);
      word({2'b00, enc4(4'(x)), 5'b11111}, 10, 12'(x << 4), 2'b01);
    end
    compare("R1 R2 R4 R7 narrow");

    // wide decode: R8 R9
    do_reset(1'b1, 1'b0);
    for (int i = 0; i < 3; i++) word({1'b1, 5'(i), 1'b1, 5'(i * 7)}, 12, 12'h0, 2'b00);
    chk(locked_o == 1'b0, "R4 unlocked wide", locked_o, 0);
    put_sync(1'b1);
    for (int c = 0; c < 1024; c++)
      word({1'b1, 5'(c >> 5), 1'b1, 5'(c)}, 12, 12'(c), 2'b00);
    for (int x = 0; x < 32; x++) begin
      word({6'b011111, 1'b1, 5'(x)}, 12, 12'(x), 2'b10);
      word({1'b1, 5'(x), 6'b011111}, 12, 12'(x << 5), 2'b01);
    end
    compare("R8 wide");

    realign(1'b0);
    realign(1'b1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog R5 act=%0d exp=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule